// File: doc/BRIEF.md
# Multiplexed I/O Channel Request Sequencer

This block is the request side of an I/O channel that is shared by up to sixteen device controllers. Each controller has its own service request line. A request sets a per-device latch. A priority encoder reduces the pending latches to one device number, and that number indexes a per-device context store. Each context entry holds an order word, an address word, a next-operation code and a bank field.

Toward the I/O processor the channel raises a single service request. The channel also forms one stage of a poll daisy chain. When the poll reaches a channel with work pending, that channel stops the poll and takes the transfer. It then copies the winning context into working registers and sends a command back on the device's own request line.

A start-I/O command seizes the channel for one device. While it is outstanding, all other requests are masked. When the channel handles it, the device's operation code is forced to descriptor fetch, so that the device's next service begins with a fetch. The channel then reports completion to the processor and acknowledges the device on the device's behalf.

Top module: `mux_chan_seq`

## Requirements
- R1: A high level on `dev_req_i[n]` at a rising edge sets that device's latch. `chan_req_o` is high from that edge on. It drops at the edge that completes the last pending service.
- R2: When several latches are set, the grant goes to the lowest device number.
- R3: `poll_o` follows `poll_i` while `chan_req_o` is low and is held low while it is high. A grant happens only at an edge where `poll_i` was high, the sequencer was idle, and no start-I/O was outstanding.
- R4: After the grant edge, `cmd_line_o` is one-hot on the granted device for exactly one cycle. In the same cycle `act_dev_o`, `wk_order_o`, `wk_addr_o` and `wk_state_o` show that device's stored context. Every command matches a device whose latch is set.
- R5: `sio_valid_i` with device d sets latch d and masks every other latch. At the next idle edge, the channel writes code 1 into d's operation field and clears latch d. At that same edge, `sio_done_o` and `sio_ack_o` rise for one cycle and no command is issued. A start-I/O that arrives while one is outstanding is ignored.
- R6: The first service of a device after its start-I/O loads operation code 1 (descriptor fetch).
- R7: `done_i` during the wait phase after a command stores `done_state_i`, `done_order_i` and `done_addr_i` into the active device's context and clears its latch. At any other time `done_i` has no effect.
- R8: Operation codes are 0 idle, 1 descriptor fetch, 2 data read, 3 data write and 4 done. `mod_sel_o` and `addr_hi_o` are zero except while a service with code 2 or 3 is in progress.
- R9: `bank_we_i` stores bits 15:12 of `bank_order_i` as the device's bank field. During a read or write service, bits 13:12 appear on `mod_sel_o` and bits 15:14 appear on `addr_hi_o`.
- R10: A stored operation code from 5 to 15 loads into `wk_state_o` as 0.
- R11: After reset all latches are clear, every context is zero, and all outputs except `poll_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_req_i | input | 16 | Per-device service request lines |
| sio_valid_i | input | 1 | Start-I/O command strobe |
| sio_dev_i | input | 4 | Device addressed by start-I/O |
| bank_we_i | input | 1 | Set-bank order strobe |
| bank_dev_i | input | 4 | Device addressed by set-bank |
| bank_order_i | input | 16 | Set-bank order word |
| poll_i | input | 1 | Poll from upstream |
| done_i | input | 1 | Service cycle complete |
| done_state_i | input | 4 | Next operation code to store |
| done_order_i | input | 16 | Order word to store |
| done_addr_i | input | 16 | Address word to store |
| chan_req_o | output | 1 | Channel service request to processor |
| poll_o | output | 1 | Poll to downstream |
| sio_done_o | output | 1 | Start-I/O completion to processor |
| sio_ack_o | output | 1 | Acknowledge supplied on device's behalf |
| cmd_line_o | output | 16 | One-hot command on device request line |
| act_dev_o | output | 4 | Active device number |
| wk_state_o | output | 4 | Working operation code |
| wk_order_o | output | 16 | Working order word |
| wk_addr_o | output | 16 | Working address word |
| mod_sel_o | output | 2 | Processor module select |
| addr_hi_o | output | 2 | Upper memory address bits |

## Verification
A request is latched at one rising edge, and the channel request is visible right after that edge. A grant taken at an edge puts the command and the working context on the outputs in the cycle that follows. `done_i` takes effect only when it is sampled at the edge after the command cycle. A start-I/O shows its completion pulse two edges after the strobe, and a masked device is granted one edge after that. The bench drives and samples on falling edges. A scoreboard queue holds each expected command or start-I/O completion in order. A falling-edge monitor pops one entry for every command cycle or completion pulse, so a late, early, extra or missing event is caught.

// File: rtl/mchan_pkg.sv
package mchan_pkg;
  localparam int W_OP = 4;

  typedef enum logic [W_OP-1:0] {
    OP_IDLE  = 4'd0,
    OP_FETCH = 4'd1,
    OP_READ  = 4'd2,
    OP_WRITE = 4'd3,
    OP_DONE  = 4'd4
  } op_code_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_CMD  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  // reserved codes fold to idle on load
  function automatic logic [W_OP-1:0] norm_op(input logic [W_OP-1:0] s);
    return (s > OP_DONE) ? OP_IDLE : s;
  endfunction
endpackage

// File: rtl/mchan_req_bank.sv
module mchan_req_bank #(
  parameter int N_DEV = 16,
  parameter int W_IDX = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] dev_req_i,
  input  logic             sio_valid_i,
  input  logic [W_IDX-1:0] sio_idx_i,
  input  logic             sio_clr_i,
  input  logic             clr_i,
  input  logic [W_IDX-1:0] clr_idx_i,
  output logic             sio_pend_o,
  output logic [W_IDX-1:0] sio_idx_o,
  output logic [N_DEV-1:0] latch_o,
  output logic             any_o,
  output logic [W_IDX-1:0] win_idx_o
);
  logic [N_DEV-1:0] latch_q, set_vec, clr_vec, eff_vec;
  logic             sio_pend_q, sio_take;
  logic [W_IDX-1:0] sio_idx_q;

  assign sio_take = sio_valid_i & ~sio_pend_q;
  assign set_vec  = dev_req_i | (sio_take ? (N_DEV'(1) << sio_idx_i) : '0);
  assign clr_vec  = clr_i ? (N_DEV'(1) << clr_idx_i) : '0;

  for (genvar g = 0; g < N_DEV; g++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         latch_q[g] <= 1'b0;
      else if (set_vec[g]) latch_q[g] <= 1'b1;
      else if (clr_vec[g]) latch_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sio_pend_q <= 1'b0;
      sio_idx_q  <= '0;
    end else if (sio_take) begin
      sio_pend_q <= 1'b1;
      sio_idx_q  <= sio_idx_i;
    end else if (sio_clr_i) begin
      sio_pend_q <= 1'b0;
    end
  end

  // start-I/O masks every other device
  assign eff_vec = sio_pend_q ? (latch_q & (N_DEV'(1) << sio_idx_q)) : latch_q;

  always_comb begin
    win_idx_o = '0;
    for (int i = N_DEV - 1; i >= 0; i--) begin
      if (eff_vec[i]) win_idx_o = W_IDX'(i);
    end
  end

  assign any_o      = |eff_vec;
  assign latch_o    = latch_q;
  assign sio_pend_o = sio_pend_q;
  assign sio_idx_o  = sio_idx_q;
endmodule

// File: rtl/mchan_ctx_store.sv
module mchan_ctx_store
  import mchan_pkg::*;
#(
  parameter int N_DEV  = 16,
  parameter int W_IDX  = 4,
  parameter int W_WORD = 16,
  parameter int W_AUX  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              st_we_i,
  input  logic              wd_we_i,
  input  logic [W_IDX-1:0]  wr_idx_i,
  input  logic [W_OP-1:0]   st_data_i,
  input  logic [W_WORD-1:0] order_data_i,
  input  logic [W_WORD-1:0] addr_data_i,
  input  logic              aux_we_i,
  input  logic [W_IDX-1:0]  aux_idx_i,
  input  logic [W_AUX-1:0]  aux_data_i,
  input  logic [W_IDX-1:0]  rd_idx_i,
  output logic [W_OP-1:0]   rd_state_o,
  output logic [W_WORD-1:0] rd_order_o,
  output logic [W_WORD-1:0] rd_addr_o,
  output logic [W_AUX-1:0]  rd_aux_o
);
  logic [W_OP-1:0]   state_q [N_DEV];
  logic [W_WORD-1:0] order_q [N_DEV];
  logic [W_WORD-1:0] addr_q  [N_DEV];
  logic [W_AUX-1:0]  aux_q   [N_DEV];

  for (genvar g = 0; g < N_DEV; g++) begin : g_ent
    logic hit_wr, hit_aux;
    assign hit_wr  = (wr_idx_i == W_IDX'(g));
    assign hit_aux = (aux_idx_i == W_IDX'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        state_q[g] <= OP_IDLE;
        order_q[g] <= '0;
        addr_q[g]  <= '0;
        aux_q[g]   <= '0;
      end else begin
        if (st_we_i && hit_wr) state_q[g] <= st_data_i;
        if (wd_we_i && hit_wr) begin
          order_q[g] <= order_data_i;
          addr_q[g]  <= addr_data_i;
        end
        if (aux_we_i && hit_aux) aux_q[g] <= aux_data_i;
      end
    end
  end

  assign rd_state_o = state_q[rd_idx_i];
  assign rd_order_o = order_q[rd_idx_i];
  assign rd_addr_o  = addr_q[rd_idx_i];
  assign rd_aux_o   = aux_q[rd_idx_i];
endmodule

// File: rtl/mchan_seq_ctrl.sv
module mchan_seq_ctrl
  import mchan_pkg::*;
#(
  parameter int N_DEV  = 16,
  parameter int W_IDX  = 4,
  parameter int W_WORD = 16,
  parameter int W_AUX  = 4,
  localparam int W_HALF = W_AUX / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              poll_i,
  input  logic              done_i,
  input  logic [W_OP-1:0]   done_state_i,
  input  logic              sio_pend_i,
  input  logic [W_IDX-1:0]  sio_idx_i,
  input  logic              any_i,
  input  logic [W_IDX-1:0]  win_idx_i,
  input  logic [W_OP-1:0]   rd_state_i,
  input  logic [W_WORD-1:0] rd_order_i,
  input  logic [W_WORD-1:0] rd_addr_i,
  input  logic [W_AUX-1:0]  rd_aux_i,
  output logic              st_we_o,
  output logic              wd_we_o,
  output logic [W_IDX-1:0]  wr_idx_o,
  output logic [W_OP-1:0]   st_data_o,
  output logic              clr_o,
  output logic              sio_clr_o,
  output logic              sio_done_o,
  output logic              sio_ack_o,
  output logic              busy_o,
  output logic [N_DEV-1:0]  cmd_line_o,
  output logic [W_IDX-1:0]  act_idx_o,
  output logic [W_OP-1:0]   wk_state_o,
  output logic [W_WORD-1:0] wk_order_o,
  output logic [W_WORD-1:0] wk_addr_o,
  output logic [W_HALF-1:0] mod_sel_o,
  output logic [W_HALF-1:0] addr_hi_o
);
  seq_state_e        sq_q, sq_d;
  logic              sio_go, grant, fin, rw_act, sio_done_q;
  logic [W_IDX-1:0]  act_q;
  logic [W_OP-1:0]   wk_state_q;
  logic [W_WORD-1:0] wk_order_q, wk_addr_q;
  logic [W_AUX-1:0]  wk_aux_q;

  assign sio_go = (sq_q == SQ_IDLE) && sio_pend_i;
  assign grant  = (sq_q == SQ_IDLE) && !sio_pend_i && poll_i && any_i;
  assign fin    = (sq_q == SQ_WAIT) && done_i;

  always_comb begin
    sq_d = sq_q;
    unique case (sq_q)
      SQ_IDLE: if (grant) sq_d = SQ_CMD;
      SQ_CMD:  sq_d = SQ_WAIT;
      SQ_WAIT: if (done_i) sq_d = SQ_IDLE;
      default: sq_d = SQ_IDLE;
    endcase
  end

  assign st_we_o   = sio_go | fin;
  assign wd_we_o   = fin;
  assign wr_idx_o  = sio_go ? sio_idx_i : act_q;
  assign st_data_o = sio_go ? OP_FETCH : done_state_i;
  assign clr_o     = sio_go | fin;
  assign sio_clr_o = sio_go;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q       <= SQ_IDLE;
      act_q      <= '0;
      wk_state_q <= OP_IDLE;
      wk_order_q <= '0;
      wk_addr_q  <= '0;
      wk_aux_q   <= '0;
      sio_done_q <= 1'b0;
    end else begin
      sq_q       <= sq_d;
      sio_done_q <= sio_go;
      if (grant) begin
        act_q      <= win_idx_i;
        wk_state_q <= norm_op(rd_state_i);
        wk_order_q <= rd_order_i;
        wk_addr_q  <= rd_addr_i;
        wk_aux_q   <= rd_aux_i;
      end
    end
  end

  assign busy_o     = (sq_q != SQ_IDLE);
  assign rw_act     = busy_o && (wk_state_q == OP_READ || wk_state_q == OP_WRITE);
  assign mod_sel_o  = rw_act ? wk_aux_q[W_HALF-1:0] : '0;
  assign addr_hi_o  = rw_act ? wk_aux_q[W_AUX-1:W_HALF] : '0;
  assign cmd_line_o = (sq_q == SQ_CMD) ? (N_DEV'(1) << act_q) : '0;
  assign act_idx_o  = act_q;
  assign wk_state_o = wk_state_q;
  assign wk_order_o = wk_order_q;
  assign wk_addr_o  = wk_addr_q;
  assign sio_done_o = sio_done_q;
  assign sio_ack_o  = sio_done_q;

  AST_GRANT_POLLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sq_q == SQ_CMD) |-> $past(poll_i)); // R3
  AST_SIO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_done_q |=> !sio_done_q); // R5
  AST_SIO_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sio_done_q |-> (cmd_line_o == '0)); // R5
endmodule

// File: rtl/mux_chan_seq.sv
module mux_chan_seq
  import mchan_pkg::*;
#(
  parameter int N_DEV  = 16,
  parameter int W_WORD = 16,
  parameter int W_AUX  = 4,
  localparam int W_IDX  = $clog2(N_DEV),
  localparam int W_HALF = W_AUX / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_DEV-1:0]  dev_req_i,
  input  logic              sio_valid_i,
  input  logic [W_IDX-1:0]  sio_dev_i,
  input  logic              bank_we_i,
  input  logic [W_IDX-1:0]  bank_dev_i,
  input  logic [W_WORD-1:0] bank_order_i,
  input  logic              poll_i,
  input  logic              done_i,
  input  logic [W_OP-1:0]   done_state_i,
  input  logic [W_WORD-1:0] done_order_i,
  input  logic [W_WORD-1:0] done_addr_i,
  output logic              chan_req_o,
  output logic              poll_o,
  output logic              sio_done_o,
  output logic              sio_ack_o,
  output logic [N_DEV-1:0]  cmd_line_o,
  output logic [W_IDX-1:0]  act_dev_o,
  output logic [W_OP-1:0]   wk_state_o,
  output logic [W_WORD-1:0] wk_order_o,
  output logic [W_WORD-1:0] wk_addr_o,
  output logic [W_HALF-1:0] mod_sel_o,
  output logic [W_HALF-1:0] addr_hi_o
);
  logic              sio_pend, sio_clr, any, clr, st_we, wd_we, busy;
  logic [W_IDX-1:0]  sio_idx, win_idx, wr_idx;
  logic [N_DEV-1:0]  latch;
  logic [W_OP-1:0]   st_data, rd_state;
  logic [W_WORD-1:0] rd_order, rd_addr;
  logic [W_AUX-1:0]  rd_aux;

  mchan_req_bank #(.N_DEV(N_DEV), .W_IDX(W_IDX)) u_req (
    .clk_i, .rst_ni,
    .dev_req_i,
    .sio_valid_i,
    .sio_idx_i  (sio_dev_i),
    .sio_clr_i  (sio_clr),
    .clr_i      (clr),
    .clr_idx_i  (wr_idx),
    .sio_pend_o (sio_pend),
    .sio_idx_o  (sio_idx),
    .latch_o    (latch),
    .any_o      (any),
    .win_idx_o  (win_idx)
  );

  mchan_ctx_store #(.N_DEV(N_DEV), .W_IDX(W_IDX), .W_WORD(W_WORD), .W_AUX(W_AUX)) u_ctx (
    .clk_i, .rst_ni,
    .st_we_i      (st_we),
    .wd_we_i      (wd_we),
    .wr_idx_i     (wr_idx),
    .st_data_i    (st_data),
    .order_data_i (done_order_i),
    .addr_data_i  (done_addr_i),
    .aux_we_i     (bank_we_i),
    .aux_idx_i    (bank_dev_i),
    .aux_data_i   (bank_order_i[W_WORD-1 -: W_AUX]),
    .rd_idx_i     (win_idx),
    .rd_state_o   (rd_state),
    .rd_order_o   (rd_order),
    .rd_addr_o    (rd_addr),
    .rd_aux_o     (rd_aux)
  );

  mchan_seq_ctrl #(.N_DEV(N_DEV), .W_IDX(W_IDX), .W_WORD(W_WORD), .W_AUX(W_AUX)) u_ctrl (
    .clk_i, .rst_ni,
    .poll_i, .done_i, .done_state_i,
    .sio_pend_i (sio_pend),
    .sio_idx_i  (sio_idx),
    .any_i      (any),
    .win_idx_i  (win_idx),
    .rd_state_i (rd_state),
    .rd_order_i (rd_order),
    .rd_addr_i  (rd_addr),
    .rd_aux_i   (rd_aux),
    .st_we_o    (st_we),
    .wd_we_o    (wd_we),
    .wr_idx_o   (wr_idx),
    .st_data_o  (st_data),
    .clr_o      (clr),
    .sio_clr_o  (sio_clr),
    .sio_done_o, .sio_ack_o,
    .busy_o     (busy),
    .cmd_line_o,
    .act_idx_o  (act_dev_o),
    .wk_state_o, .wk_order_o, .wk_addr_o,
    .mod_sel_o, .addr_hi_o
  );

  assign chan_req_o = any;
  assign poll_o     = poll_i & ~any; // holding the poll while work is pending

  AST_CMD_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_line_o) |-> (|(cmd_line_o & latch))); // R4
  AST_CMD_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_line_o) |-> busy); // R4
endmodule

// File: tb/tb_mux_chan_seq.sv
module tb_mux_chan_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dev_req_i = '0;
  logic        sio_valid_i = 1'b0;
  logic [3:0]  sio_dev_i = '0;
  logic        bank_we_i = 1'b0;
  logic [3:0]  bank_dev_i = '0;
  logic [15:0] bank_order_i = '0;
  logic        poll_i = 1'b0;
  logic        done_i = 1'b0;
  logic [3:0]  done_state_i = '0;
  logic [15:0] done_order_i = '0;
  logic [15:0] done_addr_i = '0;
  logic        chan_req_o, poll_o, sio_done_o, sio_ack_o;
  logic [15:0] cmd_line_o, wk_order_o, wk_addr_o;
  logic [3:0]  act_dev_o, wk_state_o;
  logic [1:0]  mod_sel_o, addr_hi_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          is_sio;
    int          dev;
    logic [3:0]  st;
    logic [15:0] order;
    logic [15:0] addr;
    logic [1:0]  mod;
    logic [1:0]  hi;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  mux_chan_seq dut (
    .clk_i(clk), .rst_ni(rst_n),
    .dev_req_i, .sio_valid_i, .sio_dev_i,
    .bank_we_i, .bank_dev_i, .bank_order_i,
    .poll_i, .done_i, .done_state_i, .done_order_i, .done_addr_i,
    .chan_req_o, .poll_o, .sio_done_o, .sio_ack_o,
    .cmd_line_o, .act_dev_o, .wk_state_o, .wk_order_o, .wk_addr_o,
    .mod_sel_o, .addr_hi_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_cmd(string tag, int dev, logic [3:0] st, logic [15:0] ord,
                         logic [15:0] adr, logic [1:0] md, logic [1:0] hi);
    exp_t e;
    e.is_sio = 1'b0; e.dev = dev; e.st = st; e.order = ord; e.addr = adr;
    e.mod = md; e.hi = hi; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic exp_sio(string tag, int dev);
    exp_t e;
    e.is_sio = 1'b1; e.dev = dev; e.st = '0; e.order = '0; e.addr = '0;
    e.mod = '0; e.hi = '0; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic pulse_req(logic [15:0] v);
    dev_req_i = v;
    tick();
    dev_req_i = '0;
  endtask

  task automatic set_bank(int dev, logic [15:0] ord);
    bank_we_i = 1'b1; bank_dev_i = 4'(dev); bank_order_i = ord;
    tick();
    bank_we_i = 1'b0;
  endtask

  // grant edge, command cycle, then completion sampled in the wait phase
  task automatic serve(logic [3:0] st, logic [15:0] ord, logic [15:0] adr);
    poll_i = 1'b1;
    tick();
    poll_i = 1'b0;
    tick();
    done_i = 1'b1; done_state_i = st; done_order_i = ord; done_addr_i = adr;
    tick();
    done_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished && (cmd_line_o != '0 || sio_done_o)) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL unexpected event R4 act=cmd:%0h sio:%0b exp=none", cmd_line_o, sio_done_o);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " kind"}, 32'(sio_done_o), 32'(e.is_sio));
        if (e.is_sio) begin
          chk({e.tag, " ack"}, 32'(sio_ack_o), 32'd1);
          chk({e.tag, " no cmd"}, 32'(cmd_line_o), 32'd0);
        end else begin
          chk({e.tag, " line"}, 32'(cmd_line_o), 32'(16'd1 << e.dev));
          chk({e.tag, " dev"}, 32'(act_dev_o), 32'(e.dev));
          chk({e.tag, " state"}, 32'(wk_state_o), 32'(e.st));
          chk({e.tag, " order"}, 32'(wk_order_o), 32'(e.order));
          chk({e.tag, " addr"}, 32'(wk_addr_o), 32'(e.addr));
          chk({e.tag, " mod"}, 32'(mod_sel_o), 32'(e.mod));
          chk({e.tag, " hi"}, 32'(addr_hi_o), 32'(e.hi));
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R4 act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R11 reset state
    chk("R11 chan_req", 32'(chan_req_o), 0);
    chk("R11 cmd_line", 32'(cmd_line_o), 0);
    chk("R11 sio_done", 32'(sio_done_o), 0);
    chk("R11 wk_state", 32'(wk_state_o), 0);
    chk("R11 bank", 32'({addr_hi_o, mod_sel_o}), 0);
    poll_i = 1'b1; #1;
    chk("R3 poll passes", 32'(poll_o), 1);
    poll_i = 1'b0;

    // R1 latch and channel request
    pulse_req(16'h0040);
    chk("R1 chan_req set", 32'(chan_req_o), 1);
    poll_i = 1'b1; #1;
    chk("R3 poll held", 32'(poll_o), 0);
    exp_cmd("R4 dev6 first", 6, 4'd0, 16'h0000, 16'h0000, 2'd0, 2'd0);
    serve(4'd2, 16'h1234, 16'hABCD);
    chk("R1 chan_req drops", 32'(chan_req_o), 0);

    // R9 bank field: bits 15:14 -> hi=2, 13:12 -> mod=3
    set_bank(6, 16'hB000);

    // R2 priority
    pulse_req(16'h0048);
    exp_cmd("R2 dev3 wins", 3, 4'd0, 16'h0000, 16'h0000, 2'd0, 2'd0);
    serve(4'd3, 16'h0F0F, 16'h5555);
    chk("R1 chan_req stays", 32'(chan_req_o), 1);
    exp_cmd("R8 R9 dev6 read", 6, 4'd2, 16'h1234, 16'hABCD, 2'd3, 2'd2);
    serve(4'd9, 16'h1111, 16'h2222);

    // R7 done outside wait phase ignored
    done_i = 1'b1; done_state_i = 4'd4; done_order_i = 16'hFFFF; done_addr_i = 16'hFFFF;
    tick();
    done_i = 1'b0;
    chk("R7 ignored no cmd", 32'(cmd_line_o), 0);
    pulse_req(16'h0040);
    exp_cmd("R10 R7 dev6 reserved", 6, 4'd0, 16'h1111, 16'h2222, 2'd0, 2'd0);
    serve(4'd4, 16'h1111, 16'h2222);

    // R9 write order pair: aux 7 -> hi=1 mod=3
    set_bank(3, 16'h7000);
    pulse_req(16'h0008);
    exp_cmd("R8 R9 dev3 write", 3, 4'd3, 16'h0F0F, 16'h5555, 2'd3, 2'd1);
    serve(4'd0, 16'h0F0F, 16'h5555);

    // R5 start-I/O masks pending dev2
    pulse_req(16'h0004);
    sio_valid_i = 1'b1; sio_dev_i = 4'd9;
    exp_sio("R5 sio dev9", 9);
    exp_cmd("R5 dev2 after sio", 2, 4'd0, 16'h0000, 16'h0000, 2'd0, 2'd0);
    tick();
    sio_valid_i = 1'b0;
    poll_i = 1'b1;
    tick();
    tick();
    poll_i = 1'b0;
    tick();
    done_i = 1'b1; done_state_i = 4'd0; done_order_i = 16'h0; done_addr_i = 16'h0;
    tick();
    done_i = 1'b0;
    chk("R5 sio dev latch cleared", 32'(chan_req_o), 0);

    // R6 descriptor fetch after start-I/O
    pulse_req(16'h0200);
    exp_cmd("R6 dev9 fetch", 9, 4'd1, 16'h0000, 16'h0000, 2'd0, 2'd0);
    serve(4'd0, 16'h0, 16'h0);

    repeat (3) tick();
    chk("R4 all events seen", 32'(exp_q.size()), 0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule